// File: doc/BRIEF.md
# Receiver Flow-Control Guard

This block drives the active-low request-to-send pin of a serial receiver so that the far-end transmitter pauses before the receive FIFO overflows. Software normally sets or clears one output-port bit to drive the pin. When automatic flow control is enabled, the block also negates the pin when a new character's start bit is seen while the FIFO is already full. That character can still be held in the receiver's shift stage. The software bit is left unchanged, and the pin returns to software control as soon as a FIFO entry is popped.

The block also watches for the character after that one. If another start bit arrives while the FIFO is still full and no entry has been popped since the held character began, that character cannot be stored. The block raises a sticky overrun flag. Serial sampling and the FIFO storage are outside this block. All pins are plain level or single-cycle strobe controls with no valid/ready data path, so there is no back-pressure at the block's edge.

Top module: `rx_flow_guard`

## Requirements
- R1: After reset the overrun flag is 0 and no character is held, so `rts_n` equals the inverse of `sw_rts`.
- R2: With `auto_en` at 0, `rts_n` always equals the inverse of `sw_rts`, whatever `start_det`, `fifo_full` and `pop` do.
- R3: With `auto_en` and `sw_rts` at 1, a `start_det` pulse while `fifo_full` is 1 and `pop` is 0 drives `rts_n` to 1 from the next cycle on. `sw_rts` is not changed by this.
- R4: While `sw_rts` is 0, `rts_n` is 1 whatever the hold state.
- R5: A `pop` pulse ends the hold. From the next cycle `rts_n` again equals the inverse of `sw_rts`.
- R6: A `start_det` pulse in the same cycle as `pop`, with `fifo_full` at 1, counts as arriving with a free slot. It causes neither a hold nor an overrun.
- R7: A `start_det` pulse while `fifo_full` is 0 causes neither a hold nor an overrun.
- R8: A `start_det` pulse while `fifo_full` is 1, with a character already held and no `pop` since, sets `overrun` from the next cycle. This happens whether or not `auto_en` is 1.
- R9: `overrun` stays 1 until `err_clr` or `rx_rst` is pulsed, and is 0 from the next cycle. If `err_clr` and a new overrun event fall in the same cycle, the flag stays set.
- R10: `rx_rst` clears the held character and the overrun flag at the next edge, and masks all events in its own cycle.
- R11: Clearing `auto_en` while a character is held returns `rts_n` at once, in the same cycle, to the inverse of `sw_rts`. The held state is kept, and setting `auto_en` again negates the pin again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rts | input | 1 | Software output-port bit; 1 requests RTS asserted |
| auto_en | input | 1 | Enables automatic RTS negation by the receiver |
| start_det | input | 1 | One-cycle strobe on a valid start bit |
| fifo_full | input | 1 | Receive FIFO full level |
| pop | input | 1 | One-cycle strobe when the FIFO is read |
| err_clr | input | 1 | One-cycle error-reset strobe |
| rx_rst | input | 1 | One-cycle receiver-reset strobe |
| rts_n | output | 1 | Request-to-send pin, active low |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The start strobe is applied against four settings: FIFO not full, FIFO full, FIFO full with a pop in the same cycle, and FIFO full with a character already held. Each setting separates a different outcome: no effect, a hold, a pop taking priority, and an overrun. The same patterns run with automatic control on and off, and with the software bit high and low. This shows that the hold is gated by both bits while overrun tracking never is. Clears are applied alone, together with a new overrun event, and through the receiver reset, to check the stickiness and the priority between set and clear.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  typedef enum logic {
    SLOT_FREE    = 1'b0,
    SLOT_CLAIMED = 1'b1
  } slot_state_e;

  typedef struct packed {
    logic claim;
    logic release_slot;
    logic over;
    logic clear_err;
  } rfg_events_t;
endpackage

// File: rtl/rfg_event_decode.sv
module rfg_event_decode
  import rfg_pkg::*;
(
  input  logic        start_det,
  input  logic        fifo_full,
  input  logic        pop,
  input  logic        err_clr,
  input  logic        rx_rst,
  input  slot_state_e slot_state,
  output rfg_events_t ev
);
  logic arrive_full;

  always_comb begin
    arrive_full     = start_det && fifo_full && !pop && !rx_rst;
    ev.claim        = arrive_full;
    ev.release_slot = pop && !rx_rst;
    ev.over         = arrive_full && (slot_state == SLOT_CLAIMED);
    ev.clear_err    = err_clr || rx_rst;
  end
endmodule

// File: rtl/rfg_slot_tracker.sv
module rfg_slot_tracker
  import rfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_rst,
  input  rfg_events_t ev,
  output slot_state_e slot_state
);
  slot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rx_rst)               state_d = SLOT_FREE;
    else if (ev.release_slot) state_d = SLOT_FREE;
    else if (ev.claim)        state_d = SLOT_CLAIMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_FREE;
    else        state_q <= state_d;
  end

  assign slot_state = state_q;
endmodule

// File: rtl/rfg_overrun_latch.sv
module rfg_overrun_latch
  import rfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rfg_events_t ev,
  output logic        overrun
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag_q <= 1'b0;
    else if (ev.over)      flag_q <= 1'b1;
    else if (ev.clear_err) flag_q <= 1'b0;
  end

  assign overrun = flag_q;
endmodule

// File: rtl/rfg_rts_drive.sv
module rfg_rts_drive
  import rfg_pkg::*;
(
  input  logic        sw_rts,
  input  logic        auto_en,
  input  slot_state_e slot_state,
  output logic        rts_n
);
  logic auto_hold;

  always_comb begin
    auto_hold = auto_en && (slot_state == SLOT_CLAIMED);
    rts_n     = !(sw_rts && !auto_hold);
  end
endmodule

// File: rtl/rx_flow_guard.sv
module rx_flow_guard
  import rfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rts,
  input  logic auto_en,
  input  logic start_det,
  input  logic fifo_full,
  input  logic pop,
  input  logic err_clr,
  input  logic rx_rst,
  output logic rts_n,
  output logic overrun
);
  rfg_events_t ev;
  slot_state_e slot_state;

  rfg_event_decode u_dec (
    .start_det (start_det),
    .fifo_full (fifo_full),
    .pop       (pop),
    .err_clr   (err_clr),
    .rx_rst    (rx_rst),
    .slot_state(slot_state),
    .ev        (ev)
  );

  rfg_slot_tracker u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_rst    (rx_rst),
    .ev        (ev),
    .slot_state(slot_state)
  );

  rfg_overrun_latch u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .overrun(overrun)
  );

  rfg_rts_drive u_rts (
    .sw_rts    (sw_rts),
    .auto_en   (auto_en),
    .slot_state(slot_state),
    .rts_n     (rts_n)
  );
endmodule

// File: rtl/rx_flow_guard_chk.sv
module rx_flow_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_rts,
  input logic auto_en,
  input logic start_det,
  input logic fifo_full,
  input logic pop,
  input logic err_clr,
  input logic rx_rst,
  input logic rts_n,
  input logic overrun
);
  a_r2_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (rts_n == !sw_rts));

  a_r4_sw_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rts |-> rts_n);

  a_r3_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && fifo_full && !pop && !rx_rst) |=> (rts_n || !auto_en || !sw_rts));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (rts_n == !sw_rts));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !err_clr && !rx_rst) |=> overrun);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst || (err_clr && !(start_det && fifo_full))) |=> !overrun);

  a_r8_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(start_det && fifo_full && !pop));
endmodule

bind rx_flow_guard rx_flow_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rts(sw_rts), .auto_en(auto_en),
  .start_det(start_det), .fifo_full(fifo_full), .pop(pop),
  .err_clr(err_clr), .rx_rst(rx_rst), .rts_n(rts_n), .overrun(overrun)
);

// File: tb/rx_flow_guard_test.sv
`timescale 1ns/1ps
module rx_flow_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rts = 1'b0, auto_en = 1'b0, start_det = 1'b0, fifo_full = 1'b0;
  logic pop = 1'b0, err_clr = 1'b0, rx_rst = 1'b0;
  logic rts_n, overrun;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_flow_guard uut (
    .clk(clk), .rst_n(rst_n), .sw_rts(sw_rts), .auto_en(auto_en),
    .start_det(start_det), .fifo_full(fifo_full), .pop(pop),
    .err_clr(err_clr), .rx_rst(rx_rst), .rts_n(rts_n), .overrun(overrun)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_det = 1'b1; cyc(); start_det = 1'b0;
  endtask

  task automatic pulse_pop();
    pop = 1'b1; cyc(); pop = 1'b0;
  endtask

  task automatic quiet();
    sw_rts = 1'b1; auto_en = 1'b1; fifo_full = 1'b0;
    rx_rst = 1'b1; cyc(); rx_rst = 1'b0; cyc();
  endtask

  task automatic t_reset();
    check("R1 overrun after reset", overrun, 1'b0);
    check("R1 rts_n after reset sw=0", rts_n, 1'b1);
    sw_rts = 1'b1; auto_en = 1'b1; #1;
    check("R1 rts_n after reset sw=1", rts_n, 1'b0);
  endtask

  task automatic t_manual();
    quiet(); auto_en = 1'b0; fifo_full = 1'b1;
    pulse_start();
    check("R2 manual start while full", rts_n, 1'b0);
    sw_rts = 1'b0; #1;
    check("R2 manual sw low", rts_n, 1'b1);
    sw_rts = 1'b1; #1;
    check("R2 manual sw high", rts_n, 1'b0);
  endtask

  task automatic t_hold_release();
    quiet(); fifo_full = 1'b1;
    pulse_start();
    check("R3 negate on start while full", rts_n, 1'b1);
    cyc();
    check("R3 hold persists", rts_n, 1'b1);
    pulse_pop();
    check("R5 release after pop", rts_n, 1'b0);
  endtask

  task automatic t_sw_low();
    quiet(); fifo_full = 1'b1; sw_rts = 1'b0;
    pulse_start(); pulse_pop();
    check("R4 sw low keeps rts_n high", rts_n, 1'b1);
    sw_rts = 1'b1; #1;
    check("R4 sw high returns pin", rts_n, 1'b0);
  endtask

  task automatic t_pop_same();
    quiet(); fifo_full = 1'b1;
    start_det = 1'b1; pop = 1'b1; cyc(); start_det = 1'b0; pop = 1'b0;
    check("R6 pop with start no hold", rts_n, 1'b0);
    pulse_start();
    check("R6 no overrun after pop overlap", overrun, 1'b0);
  endtask

  task automatic t_not_full();
    quiet();
    pulse_start(); pulse_start();
    check("R7 not full no hold", rts_n, 1'b0);
    check("R7 not full no overrun", overrun, 1'b0);
  endtask

  task automatic t_overrun();
    quiet(); auto_en = 1'b0; fifo_full = 1'b1;
    pulse_start();
    check("R8 no overrun on first", overrun, 1'b0);
    pulse_start();
    check("R8 overrun on second auto off", overrun, 1'b1);
    cyc(); cyc();
    check("R9 overrun sticky", overrun, 1'b1);
    err_clr = 1'b1; cyc(); err_clr = 1'b0;
    check("R9 err_clr clears", overrun, 1'b0);
  endtask

  task automatic t_set_wins();
    quiet(); fifo_full = 1'b1;
    pulse_start();
    err_clr = 1'b1; start_det = 1'b1; cyc(); err_clr = 1'b0; start_det = 1'b0;
    check("R9 set wins over clear", overrun, 1'b1);
  endtask

  task automatic t_rx_rst();
    quiet(); fifo_full = 1'b1;
    pulse_start(); pulse_start();
    check("R10 setup overrun", overrun, 1'b1);
    rx_rst = 1'b1; start_det = 1'b1; cyc(); rx_rst = 1'b0; start_det = 1'b0;
    check("R10 rx_rst clears overrun", overrun, 1'b0);
    check("R10 rx_rst clears hold", rts_n, 1'b0);
  endtask

  task automatic t_auto_toggle();
    quiet(); fifo_full = 1'b1;
    pulse_start();
    check("R11 held", rts_n, 1'b1);
    auto_en = 1'b0; #1;
    check("R11 auto off releases same cycle", rts_n, 1'b0);
    auto_en = 1'b1; #1;
    check("R11 auto on holds again", rts_n, 1'b1);
  endtask

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_manual();
    t_hold_release();
    t_sw_low();
    t_pop_same();
    t_not_full();
    t_overrun();
    t_set_wins();
    t_rx_rst();
    t_auto_toggle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule